// File: doc/BRIEF.md
# Serial ADC Read Controller

This block is the host side of a three-wire link to a successive-approximation sampling converter. On a start pulse it lowers an active-low chip select, waits a setup interval, then toggles a serial clock derived from the system clock. It captures one returned bit on every falling edge of that clock. When chip select rises again, the captured sample is placed on a result bus together with a one-cycle valid strobe.

The frame length follows the converter resolution. A frame is always the resolution plus two clocks, so 14, 12 or 10 clocks for the 12-, 10- and 8-bit variants. The first two bits of each frame are leading zeros and are dropped. The controller also enforces the gaps the converter needs: a release-and-quiet interval with a minimum chip-select high time after every frame, and a wake-up wait after reset or after the host signals that the converter has left full power-down. All intervals are given in nanoseconds and converted to system clock cycles at elaboration, always rounded up. Elaboration rejects an unsupported resolution and any divider that puts the serial clock outside 500 kHz to 48 MHz.

Top module: `sadc_rd_ctrl`

## Requirements
- R1: Every frame has exactly RES_BITS+2 serial clock falling edges while chip select is low (14 for 12-bit). Chip select stays low for SETUP_CYC + 2*SCLK_HALF*(RES_BITS+2) system cycles.
- R2: The serial clock is high whenever chip select is high. Within a frame each low and high phase lasts SCLK_HALF system cycles, so the clock is low for (RES_BITS+2)*SCLK_HALF cycles per frame.
- R3: The first falling edge of the serial clock comes SETUP_CYC+SCLK_HALF system cycles after chip select falls. SETUP_CYC is the setup time in ns rounded up to whole cycles.
- R4: The level on the data input is captured at each falling edge, so the k-th edge captures frame bit k-1. A frame is two zero bits followed by the sample, most significant bit first, and the result is the sample bits only.
- R5: valid_o is high for exactly one cycle: the first cycle in which chip select is high again. result_o takes the new sample in that cycle and holds it until the next strobe.
- R6: busy_o goes high in the cycle chip select falls. It stays high for GAP_CYC cycles after chip select rises. GAP_CYC is the larger of the quiet time and the minimum chip-select high time, each rounded up to cycles. Chip select is high for at least GAP_CYC+1 cycles between frames.
- R7: A start pulse while busy_o is high, whether during a frame or in the gap after it, is ignored: no further frame follows.
- R8: After reset busy_o is high, chip select and the serial clock are high, and valid_o is low. busy_o falls on the PWRUP_CYC-th clock edge after reset is released. No frame can start before then.
- R9: A wake pulse while idle restarts the power-up wait, keeping busy_o high for PWRUP_CYC cycles. A wake takes priority over a start in the same cycle. A wake while busy is ignored.
- R10: RES_BITS may be 8, 10 or 12 only. The 8-bit variant runs 10-clock frames and returns an 8-bit result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle request for a conversion frame |
| pwr_wake_i | input | 1 | One-cycle notice that the converter is leaving full power-down |
| busy_o | output | 1 | Frame, gap or power-up wait in progress |
| result_o | output | RES_BITS | Last captured sample |
| valid_o | output | 1 | One-cycle strobe marking a new result |
| adc_cs_n_o | output | 1 | Active-low chip select to the converter |
| adc_sclk_o | output | 1 | Serial clock to the converter, idle high |
| adc_sdata_i | input | 1 | Serial data from the converter |

## Verification
The assertions assume that start_i and pwr_wake_i are synchronous to clk and that reset is applied once at the start. They also assume the converter changes its data line only after a falling serial-clock edge, never in the same cycle the controller samples it. The bench drives its pulses one cycle wide on falling system-clock edges. Its converter model updates the data line one nanosecond after each serial-clock fall and after chip select falls, so every captured bit is the one launched on the previous edge. A second instance set to 8 bits runs beside the 12-bit one to exercise the shorter frame.

// File: rtl/sadc_rd_pkg.sv
package sadc_rd_pkg;

   typedef enum logic [2:0] {
      ST_WAKE,
      ST_IDLE,
      ST_SETUP,
      ST_SHIFT,
      ST_GAP
   } seq_state_e;

   // frame clocks = resolution plus two leading zero bits
   function automatic int frame_len(input int res);
      return res + 2;
   endfunction

   // nanoseconds to system cycles, rounded up, never below one cycle
   function automatic int ns_to_cyc(input int ns, input int khz);
      longint prod;
      longint cyc;
      prod = longint'(ns) * longint'(khz);
      cyc  = (prod + 64'd999999) / 64'd1000000;
      if (cyc < 1) cyc = 1;
      return int'(cyc);
   endfunction

   function automatic int max_of(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sadc_sclk_gen.sv
module sadc_sclk_gen #(
   parameter int SCLK_HALF = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   output logic sclk_o,
   output logic fall_o,
   output logic rise_o
);

   logic sclk_q;
   logic tick;

   generate
      if (SCLK_HALF == 1) begin : g_direct
         assign tick = run_i;
      end else begin : g_count
         localparam int PH_W = $clog2(SCLK_HALF);
         logic [PH_W-1:0] ph_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               ph_q <= '0;
            else if (!run_i || tick)
               ph_q <= '0;
            else
               ph_q <= ph_q + 1'b1;
         end

         assign tick = run_i && (ph_q == PH_W'(SCLK_HALF - 1));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         sclk_q <= 1'b1;
      else if (!run_i)
         sclk_q <= 1'b1;
      else if (tick)
         sclk_q <= ~sclk_q;
   end

   assign sclk_o = sclk_q;
   assign fall_o = tick && sclk_q;
   assign rise_o = tick && !sclk_q;

endmodule

// File: rtl/sadc_frame_seq.sv
module sadc_frame_seq
   import sadc_rd_pkg::*;
#(
   parameter int FRAME_BITS = 14,
   parameter int SETUP_CYC  = 2,
   parameter int GAP_CYC    = 1,
   parameter int PWRUP_CYC  = 250
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic wake_i,
   input  logic fall_i,
   input  logic rise_i,
   output logic cs_n_o,
   output logic busy_o,
   output logic run_o,
   output logic done_o
);

   localparam int TMR_MAX = max_of(max_of(SETUP_CYC, GAP_CYC), PWRUP_CYC);
   localparam int TMR_W   = $clog2(TMR_MAX + 1);
   localparam int BIT_W   = $clog2(FRAME_BITS + 1);

   seq_state_e       st_q, st_d;
   logic [TMR_W-1:0] tmr_q, tmr_d;
   logic [BIT_W-1:0] bits_q, bits_d;
   logic             cs_n_q, busy_q;
   logic             done_d;

   always_comb begin
      st_d   = st_q;
      tmr_d  = tmr_q;
      bits_d = bits_q;
      done_d = 1'b0;
      unique case (st_q)
         ST_WAKE: begin
            if (tmr_q == '0) st_d = ST_IDLE;
            else             tmr_d = tmr_q - 1'b1;
         end
         ST_IDLE: begin
            if (wake_i) begin
               st_d  = ST_WAKE;
               tmr_d = TMR_W'(PWRUP_CYC - 1);
            end else if (start_i) begin
               st_d   = ST_SETUP;
               tmr_d  = TMR_W'(SETUP_CYC - 1);
               bits_d = '0;
            end
         end
         ST_SETUP: begin
            if (tmr_q == '0) st_d = ST_SHIFT;
            else             tmr_d = tmr_q - 1'b1;
         end
         ST_SHIFT: begin
            if (fall_i) bits_d = bits_q + 1'b1;
            if (rise_i && (bits_q == BIT_W'(FRAME_BITS))) begin
               st_d   = ST_GAP;
               tmr_d  = TMR_W'(GAP_CYC - 1);
               done_d = 1'b1;
            end
         end
         ST_GAP: begin
            if (tmr_q == '0) st_d = ST_IDLE;
            else             tmr_d = tmr_q - 1'b1;
         end
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_WAKE;
         tmr_q  <= TMR_W'(PWRUP_CYC - 1);
         bits_q <= '0;
         cs_n_q <= 1'b1;
         busy_q <= 1'b1;
      end else begin
         st_q   <= st_d;
         tmr_q  <= tmr_d;
         bits_q <= bits_d;
         cs_n_q <= !((st_d == ST_SETUP) || (st_d == ST_SHIFT));
         busy_q <= (st_d != ST_IDLE);
      end
   end

   assign cs_n_o = cs_n_q;
   assign busy_o = busy_q;
   assign run_o  = (st_q == ST_SHIFT);
   assign done_o = done_d;

endmodule

// File: rtl/sadc_shift_cap.sv
module sadc_shift_cap #(
   parameter int RES_BITS = 12
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                fall_i,
   input  logic                sdata_i,
   input  logic                done_i,
   output logic [RES_BITS-1:0] result_o,
   output logic                valid_o
);

   // only RES_BITS are kept: the two leading zeros shift out of the top
   logic [RES_BITS-1:0] sh_q;
   logic [RES_BITS-1:0] res_q;
   logic                vld_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         sh_q <= '0;
      else if (fall_i)
         sh_q <= {sh_q[RES_BITS-2:0], sdata_i};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_q <= '0;
         vld_q <= 1'b0;
      end else begin
         vld_q <= done_i;
         if (done_i) res_q <= sh_q;
      end
   end

   assign result_o = res_q;
   assign valid_o  = vld_q;

endmodule

// File: rtl/sadc_rd_ctrl.sv
module sadc_rd_ctrl
   import sadc_rd_pkg::*;
#(
   parameter int RES_BITS    = 12,
   parameter int SYS_CLK_KHZ = 250000,
   parameter int SCLK_HALF   = 3,
   parameter int SETUP_NS    = 6,
   parameter int QUIET_NS    = 4,
   parameter int CS_HIGH_NS  = 3,
   parameter int PWRUP_NS    = 1000
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start_i,
   input  logic                pwr_wake_i,
   output logic                busy_o,
   output logic [RES_BITS-1:0] result_o,
   output logic                valid_o,
   output logic                adc_cs_n_o,
   output logic                adc_sclk_o,
   input  logic                adc_sdata_i
);

   localparam int FRAME_BITS = frame_len(RES_BITS);
   localparam int SETUP_CYC  = ns_to_cyc(SETUP_NS, SYS_CLK_KHZ);
   localparam int QUIET_CYC  = ns_to_cyc(QUIET_NS, SYS_CLK_KHZ);
   localparam int CSH_CYC    = ns_to_cyc(CS_HIGH_NS, SYS_CLK_KHZ);
   localparam int GAP_CYC    = max_of(QUIET_CYC, CSH_CYC);
   localparam int PWRUP_CYC  = ns_to_cyc(PWRUP_NS, SYS_CLK_KHZ);
   localparam int SCLK_KHZ   = SYS_CLK_KHZ / (2 * SCLK_HALF);

   // R10: elaboration checks on the parameter set
   generate
      if (RES_BITS != 8 && RES_BITS != 10 && RES_BITS != 12) begin : g_bad_res
         $error("sadc_rd_ctrl: RES_BITS must be 8, 10 or 12");
      end
      if (SCLK_HALF < 1) begin : g_bad_half
         $error("sadc_rd_ctrl: SCLK_HALF must be at least 1");
      end
      if (SCLK_KHZ > 48000 || SCLK_KHZ < 500) begin : g_bad_rate
         $error("sadc_rd_ctrl: serial clock outside 500 kHz to 48 MHz");
      end
   endgenerate

   logic run, fall, rise, done;

   sadc_sclk_gen #(
      .SCLK_HALF (SCLK_HALF)
   ) sclk_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .run_i  (run),
      .sclk_o (adc_sclk_o),
      .fall_o (fall),
      .rise_o (rise)
   );

   sadc_frame_seq #(
      .FRAME_BITS (FRAME_BITS),
      .SETUP_CYC  (SETUP_CYC),
      .GAP_CYC    (GAP_CYC),
      .PWRUP_CYC  (PWRUP_CYC)
   ) seq_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (start_i),
      .wake_i  (pwr_wake_i),
      .fall_i  (fall),
      .rise_i  (rise),
      .cs_n_o  (adc_cs_n_o),
      .busy_o  (busy_o),
      .run_o   (run),
      .done_o  (done)
   );

   sadc_shift_cap #(
      .RES_BITS (RES_BITS)
   ) cap_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .fall_i   (fall),
      .sdata_i  (adc_sdata_i),
      .done_i   (done),
      .result_o (result_o),
      .valid_o  (valid_o)
   );

endmodule

// File: rtl/sadc_rd_chk.sv
module sadc_rd_chk #(
   parameter int FRAME = 14,
   parameter int GAP   = 1
) (
   input logic clk,
   input logic rst_n,
   input logic cs_n,
   input logic sclk,
   input logic busy,
   input logic valid
);

   localparam int FC_W = $clog2(FRAME + 2);
   localparam int HC_W = $clog2(GAP + 3);

   logic            sclk_d;
   logic [FC_W-1:0] fall_cnt;
   logic [HC_W-1:0] hi_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_d   <= 1'b1;
         fall_cnt <= '0;
         hi_cnt   <= '0;
      end else begin
         sclk_d <= sclk;
         if (cs_n)
            fall_cnt <= '0;
         else if (sclk_d && !sclk && fall_cnt != '1)
            fall_cnt <= fall_cnt + 1'b1;
         if (!cs_n)
            hi_cnt <= '0;
         else if (hi_cnt != '1)
            hi_cnt <= hi_cnt + 1'b1;
      end
   end

   // R1: edge count seen when the frame closes
   assert_frame_edges_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cs_n) |-> (fall_cnt == FC_W'(FRAME)));

   // R2: clock parked high outside frames
   assert_sclk_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> sclk);

   // R5: strobe is a single cycle
   assert_valid_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      valid |=> !valid);

   // R5: strobe coincides with chip select rising
   assert_valid_at_close_R5: assert property (@(posedge clk) disable iff (!rst_n)
      valid |-> (cs_n && !$past(cs_n)));

   // R6: busy covers the whole frame
   assert_busy_in_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_n |-> busy);

   // R6: chip select high long enough between frames
   assert_cs_high_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cs_n) |-> (hi_cnt >= HC_W'(GAP + 1)));

   // R7: a frame only opens from the idle condition
   assert_start_from_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cs_n) |-> !$past(busy));

endmodule

bind sadc_rd_ctrl sadc_rd_chk #(
   .FRAME (FRAME_BITS),
   .GAP   (GAP_CYC)
) chk_i (
   .clk   (clk),
   .rst_n (rst_n),
   .cs_n  (adc_cs_n_o),
   .sclk  (adc_sclk_o),
   .busy  (busy_o),
   .valid (valid_o)
);

// File: tb/sadc_rd_ctrl_tb_top.sv
`timescale 1ns/1ps

module sadc_conv_model #(
   parameter int RES = 12
) (
   input  logic           cs_n,
   input  logic           sclk,
   input  logic [RES-1:0] word,
   output logic           sdo
);
   localparam int FB = RES + 2;
   logic [FB-1:0] fr;
   int            idx;

   initial begin
      sdo = 1'b0;
      idx = 0;
      fr  = '0;
   end

   always @(negedge cs_n) begin
      #1;
      fr  = {2'b00, word};
      idx = 0;
      sdo = fr[FB-1];
   end

   always @(negedge sclk) begin
      if (!cs_n) begin
         #1;
         idx = idx + 1;
         sdo = (idx < FB) ? fr[FB-1-idx] : 1'b0;
      end
   end

   always @(posedge cs_n) begin
      #1;
      sdo = 1'b0;
   end
endmodule

module sadc_rd_ctrl_tb_top;

   localparam int RES     = 12;
   localparam int RES_B   = 8;
   localparam int HALF    = 3;
   localparam int FRAME   = RES + 2;
   localparam int FRAME_B = RES_B + 2;
   // 4 ns period: setup 6 ns -> 2, gap max(4 ns, 3 ns) -> 1, wake 1000 ns -> 250
   localparam int SETUP_CYC = 2;
   localparam int GAP_CYC   = 1;
   localparam int PWRUP_CYC = 250;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic           rst_n, start, wake, busy, valid, cs_n, sclk, sdata;
   logic [RES-1:0] result, word;
   logic             start_b, busy_b, valid_b, cs_n_b, sclk_b, sdata_b;
   logic [RES_B-1:0] result_b, word_b;

   int n_chk = 0;
   int n_bad = 0;

   sadc_rd_ctrl #(.RES_BITS(RES), .SCLK_HALF(HALF)) dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start), .pwr_wake_i(wake),
      .busy_o(busy), .result_o(result), .valid_o(valid),
      .adc_cs_n_o(cs_n), .adc_sclk_o(sclk), .adc_sdata_i(sdata));

   sadc_conv_model #(.RES(RES)) conv_i (
      .cs_n(cs_n), .sclk(sclk), .word(word), .sdo(sdata));

   sadc_rd_ctrl #(.RES_BITS(RES_B), .SCLK_HALF(HALF)) dut_b_i (
      .clk(clk), .rst_n(rst_n), .start_i(start_b), .pwr_wake_i(1'b0),
      .busy_o(busy_b), .result_o(result_b), .valid_o(valid_b),
      .adc_cs_n_o(cs_n_b), .adc_sclk_o(sclk_b), .adc_sdata_i(sdata_b));

   sadc_conv_model #(.RES(RES_B)) conv_b_i (
      .cs_n(cs_n_b), .sclk(sclk_b), .word(word_b), .sdo(sdata_b));

   task automatic check(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   // R8: reset state, power-up wait, start ignored during the wait
   task automatic t_reset_wait();
      int k = 0;
      int lows = 0;
      rst_n = 1'b0;
      repeat (4) @(negedge clk);
      check("R8", "busy in reset", busy, 1);
      check("R8", "cs_n in reset", cs_n, 1);
      check("R2", "sclk in reset", sclk, 1);
      check("R8", "valid in reset", valid, 0);
      rst_n = 1'b1;
      forever begin
         @(negedge clk);
         start = 1'b0;
         if (!busy) break;
         k++;
         if (!cs_n) lows++;
         if (k == 10) start = 1'b1;
      end
      check("R8", "busy cycles after reset", k, PWRUP_CYC - 1);
      check("R8", "frames during wait", lows, 0);
   endtask

   // R1..R7: one frame on the 12-bit instance, optional stray requests
   task automatic t_frame(input logic [RES-1:0] w, input bit inject);
      int low = 0, falls = 0, sclk_low = 0, first_fall = 0, g = 0, lows = 0;
      logic prev = 1'b1;
      word  = w;
      start = 1'b1;
      forever begin
         @(negedge clk);
         start = 1'b0;
         wake  = 1'b0;
         if (cs_n) break;
         low++;
         if (!sclk) begin
            sclk_low++;
            if (prev) begin
               falls++;
               if (first_fall == 0) first_fall = low;
            end
         end
         prev = sclk;
         if (!busy) check("R6", "busy during frame", 0, 1);
         if (inject && low == 20) begin
            start = 1'b1;
            wake  = 1'b1;
         end
      end
      check("R1", "cs low cycles", low, SETUP_CYC + 2 * HALF * FRAME);
      check("R1", "falling edges", falls, FRAME);
      check("R2", "sclk low cycles", sclk_low, FRAME * HALF);
      check("R3", "first fall index", first_fall, SETUP_CYC + HALF + 1);
      check("R5", "valid at cs rise", valid, 1);
      check("R4", "result", int'(result), int'(w));
      if (busy) g++;
      if (inject) start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check("R5", "valid one cycle", valid, 0);
      check("R5", "result held", int'(result), int'(w));
      while (busy) begin
         g++;
         @(negedge clk);
      end
      check("R6", "busy cycles after cs rise", g, GAP_CYC);
      repeat (8) begin
         @(negedge clk);
         if (!cs_n || busy) lows++;
      end
      check(inject ? "R7" : "R6", "idle after frame", lows, 0);
   endtask

   // R9: wake and start together in idle, wake wins
   task automatic t_wake();
      int k = 0;
      int lows = 0;
      wake  = 1'b1;
      start = 1'b1;
      forever begin
         @(negedge clk);
         wake  = 1'b0;
         start = 1'b0;
         if (!busy) break;
         k++;
         if (!cs_n) lows++;
      end
      check("R9", "wait cycles after wake", k, PWRUP_CYC);
      check("R9", "frames during wake wait", lows, 0);
   endtask

   // R10: 8-bit variant frame
   task automatic t_frame8(input logic [RES_B-1:0] w);
      int low = 0, falls = 0;
      logic prev = 1'b1;
      word_b  = w;
      start_b = 1'b1;
      forever begin
         @(negedge clk);
         start_b = 1'b0;
         if (cs_n_b) break;
         low++;
         if (!sclk_b && prev) falls++;
         prev = sclk_b;
      end
      check("R10", "8-bit falling edges", falls, FRAME_B);
      check("R10", "8-bit cs low cycles", low, SETUP_CYC + 2 * HALF * FRAME_B);
      check("R10", "8-bit valid", valid_b, 1);
      check("R10", "8-bit result", int'(result_b), int'(w));
      while (busy_b) @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      rst_n   = 1'b0;
      start   = 1'b0;
      wake    = 1'b0;
      start_b = 1'b0;
      word    = '0;
      word_b  = '0;
      t_reset_wait();
      t_frame(12'hA5C, 1'b0);
      t_frame(12'hFFF, 1'b1);
      t_frame(12'h001, 1'b0);
      t_frame(12'h800, 1'b1);
      t_wake();
      t_frame(12'h3C7, 1'b0);
      t_frame8(8'h3C);
      t_frame8(8'hFF);
      t_frame8(8'h81);
      summary();
      $finish;
   end

endmodule